// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. Software or a neighbouring block sets the frame shape on a few configuration pins: a data length of five to nine bits, a parity mode of none, even or odd, and one or two stop bits. That gives thirty legal shapes. The line rests high. A frame starts with a low start bit. The data follows with the least significant bit first. An optional parity bit comes next, and one or two high stop bits close the frame.

An external divider supplies a one-cycle `tick` once per bit period. Each tick moves the transmitter one bit forward. A character is offered with a valid/ready handshake. The block can take a character only on a tick, and only while it is idle or while that tick closes the last stop bit. A stream of characters can therefore go out with no idle gap between frames. The configuration pins are captured when a character is accepted, so changing them during a frame does not affect that frame.

Top module: `serial_frame_tx`

## Requirements
- R1: While no frame is in progress, `line_out` is 1 and `busy` is 0. `busy` is 1 from the start bit through the last stop bit.
- R2: A frame is sent as one 0 start bit, then the data bits with bit 0 first, then the parity bit if enabled, then the stop bits at 1.
- R3: `cfg_len` selects the data length as 5 + `cfg_len` for codes 0 to 4. Codes 5, 6 and 7 select 9 bits.
- R4: `cfg_parity` code 00 or 01 sends no parity bit. Code 10 sends even parity, which is the XOR of the active data bits. Code 11 sends odd parity, which is the inverse of that XOR. The parity bit sits between the last data bit and the first stop bit.
- R5: `cfg_two_stop` = 0 sends one stop bit, and `cfg_two_stop` = 1 sends two.
- R6: Each bit lasts exactly one tick period. `line_out` and `busy` change only in the cycle after a cycle with `tick` high.
- R7: `in_ready` is 1 only in a cycle with `tick` high, and only when the transmitter is idle or is on its final stop bit. A character accepted at such an edge puts the start bit on the line in the next cycle.
- R8: A character accepted on the tick that ends the final stop bit starts its start bit at once, with no idle bit between the two frames.
- R9: Bits of `in_data` at and above the selected length do not appear on the line and do not affect the parity bit.
- R10: The configuration pins are captured on acceptance. Changing them during a frame does not alter that frame.
- R11: A synchronous active-high `rst` drives the line to 1, returns the block to idle and abandons any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per bit period |
| in_valid | input | 1 | A character is offered |
| in_ready | output | 1 | A character is taken at this edge |
| in_data | input | 9 | Character; only the low bits up to the selected length are used |
| cfg_len | input | 3 | Data length code |
| cfg_parity | input | 2 | Parity mode code |
| cfg_two_stop | input | 1 | Selects two stop bits |
| line_out | output | 1 | Serial output line, high when idle |
| busy | output | 1 | A frame is in progress |

## Verification
The hardest case to reach is the seamless hand-over. A new character has to be present in exactly the tick that closes the final stop bit, and that stop bit is the first one or the second depending on the stop setting. The bench handles this by holding `tick` under its own control. It counts the bits of every frame it expects and offers the next character on that exact pulse. It then checks that the start bit follows with no gap while `busy` stays high. A second hard case is a configuration change in the middle of a frame. The bench scrambles every configuration pin right after acceptance and still expects the originally selected shape.

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int MAX_BITS = 9,
  parameter int MIN_BITS = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [MAX_BITS-1:0] in_data,
  input  logic [2:0]          cfg_len,
  input  logic [1:0]          cfg_parity,
  input  logic                cfg_two_stop,
  output logic                line_out,
  output logic                busy
);
  localparam int CW   = $clog2(MAX_BITS);
  localparam int SPAN = MAX_BITS - MIN_BITS;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2} st_t;

  st_t                 st;
  logic [MAX_BITS-1:0] shreg;
  logic [MAX_BITS-1:0] mask;
  logic [CW-1:0]       cnt;
  logic [CW-1:0]       last_idx;
  logic                par_en;
  logic                par_bit;
  logic                two_stop;
  logic                final_stop;
  logic                accept;
  int                  nbits;

  always_comb begin
    if (int'(cfg_len) > SPAN) nbits = MAX_BITS;
    else                      nbits = MIN_BITS + int'(cfg_len);
  end

  for (genvar g = 0; g < MAX_BITS; g++) begin : g_mask
    assign mask[g] = (g < nbits);
  end

  assign final_stop = (st == S_STOP2) || (st == S_STOP1 && !two_stop);
  assign in_ready   = tick && (st == S_IDLE || final_stop);
  assign accept     = in_valid && in_ready;
  assign busy       = (st != S_IDLE);

  always_comb begin
    case (st)
      S_START: line_out = 1'b0;
      S_DATA:  line_out = shreg[0];
      S_PAR:   line_out = par_bit;
      default: line_out = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      shreg    <= '0;
      cnt      <= '0;
      last_idx <= '0;
      par_en   <= 1'b0;
      par_bit  <= 1'b0;
      two_stop <= 1'b0;
    end else if (tick) begin
      if (accept) begin
        st       <= S_START;
        shreg    <= in_data & mask;
        cnt      <= '0;
        last_idx <= CW'(nbits - 1);
        par_en   <= cfg_parity[1];
        par_bit  <= (^(in_data & mask)) ^ cfg_parity[0];
        two_stop <= cfg_two_stop;
      end else begin
        case (st)
          S_START: st <= S_DATA;
          S_DATA: begin
            shreg <= shreg >> 1;
            cnt   <= cnt + 1'b1;
            if (cnt == last_idx) st <= par_en ? S_PAR : S_STOP1;
          end
          S_PAR:   st <= S_STOP1;
          S_STOP1: st <= two_stop ? S_STOP2 : S_IDLE;
          S_STOP2: st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> line_out);

  a_r2_start_follows_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!line_out && busy));

  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    (st == S_DATA) |-> (cnt <= last_idx));

  a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(line_out) && $stable(busy)));

  a_r7_ready_needs_tick: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> tick);

  a_r8_seamless: assert property (@(posedge clk) disable iff (rst)
    (busy && in_valid && in_ready) |=> (busy && !line_out));

  a_r11_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && line_out));
endmodule

// File: tb/serial_frame_tx_tb_top.sv
module serial_frame_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [8:0] in_data = '0;
  logic [2:0] cfg_len = '0;
  logic [1:0] cfg_parity = '0;
  logic       cfg_two_stop = 1'b0;
  logic       line_out;
  logic       busy;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  serial_frame_tx dut_i (
    .clk(clk), .rst(rst), .tick(tick), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_len(cfg_len), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .line_out(line_out), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit exp_ready, output logic v);
    tick = 1'b1;
    #1;
    chk(in_ready === exp_ready, "R7", "ready at tick", int'(in_ready), int'(exp_ready));
    @(negedge clk);
    tick = 1'b0;
    v = line_out;
    @(negedge clk);
    chk(line_out === v, "R6", "hold between ticks", int'(line_out), int'(v));
  endtask

  task automatic run_frame(input logic [8:0] d, input logic [2:0] lc, input logic [1:0] pm,
                           input bit two, input bit chain, input bit mangle, input string tag);
    int   n;
    logic p;
    logic v;
    bit   was_busy;
    string rd, rp, rs;
    rd = (tag != "") ? tag : "R3";
    rp = (tag != "") ? tag : "R4";
    rs = (tag != "") ? tag : "R5";
    n = (lc > 3'd4) ? 9 : 5 + int'(lc);
    p = pm[0];
    for (int i = 0; i < n; i++) p ^= d[i];
    in_data = d; cfg_len = lc; cfg_parity = pm; cfg_two_stop = two;
    in_valid = 1'b1; tick = 1'b1;
    #1;
    was_busy = busy;
    chk(in_ready === 1'b1, "R7", "ready when free", int'(in_ready), 1);
    @(negedge clk);
    tick = 1'b0; in_valid = 1'b0; in_data = ~d;
    if (mangle) begin
      cfg_len = (lc == 3'd0) ? 3'd4 : 3'd0;
      cfg_parity = ~pm;
      cfg_two_stop = ~two;
    end
    chk(line_out === 1'b0, was_busy ? "R8" : "R2", "start bit", int'(line_out), 0);
    chk(busy === 1'b1, "R1", "busy in frame", int'(busy), 1);
    @(negedge clk);
    chk(line_out === 1'b0, "R6", "start held", int'(line_out), 0);
    for (int i = 0; i < n; i++) begin
      step(1'b0, v);
      chk(v === d[i], rd, $sformatf("data bit %0d", i), int'(v), int'(d[i]));
    end
    if (pm[1]) begin
      step(1'b0, v);
      chk(v === p, rp, "parity bit", int'(v), int'(p));
    end
    step(1'b0, v);
    chk(v === 1'b1, rs, "stop bit 1", int'(v), 1);
    if (two) begin
      step(1'b0, v);
      chk(v === 1'b1, rs, "stop bit 2", int'(v), 1);
    end
    chk(busy === 1'b1, rs, "busy on last stop", int'(busy), 1);
    if (!chain) begin
      step(1'b1, v);
      chk(v === 1'b1, rs, "idle after stops", int'(v), 1);
      chk(busy === 1'b0, rs, "idle after stops busy", int'(busy), 0);
    end
  endtask

  task automatic t_reset;
    chk(line_out === 1'b1, "R11", "line in reset", int'(line_out), 1);
    chk(busy === 1'b0, "R11", "busy in reset", int'(busy), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(line_out === 1'b1, "R1", "idle line", int'(line_out), 1);
    chk(busy === 1'b0, "R1", "idle busy", int'(busy), 0);
  endtask

  task automatic t_no_tick;
    in_valid = 1'b1; in_data = 9'h0AA;
    for (int i = 0; i < 5; i++) begin
      #1;
      chk(in_ready === 1'b0, "R7", "ready without tick", int'(in_ready), 0);
      @(negedge clk);
      chk(busy === 1'b0, "R7", "no start without tick", int'(busy), 0);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_all_formats;
    logic [1:0] modes [3] = '{2'b00, 2'b10, 2'b11};
    for (int l = 0; l < 5; l++)
      for (int m = 0; m < 3; m++)
        for (int s = 0; s < 2; s++)
          run_frame(9'(37 * (l * 6 + m * 2 + s) + 11), 3'(l), modes[m], s[0], 1'b0, 1'b0, "");
  endtask

  task automatic t_chain;
    run_frame(9'h155, 3'd4, 2'b10, 1'b1, 1'b1, 1'b0, "R8");
    run_frame(9'h033, 3'd1, 2'b11, 1'b0, 1'b1, 1'b0, "R8");
    run_frame(9'h00F, 3'd3, 2'b00, 1'b0, 1'b1, 1'b0, "R8");
    run_frame(9'h0C3, 3'd3, 2'b11, 1'b1, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_high_bits;
    run_frame(9'h1E5, 3'd0, 2'b10, 1'b0, 1'b0, 1'b0, "R9");
    run_frame(9'h1C0, 3'd1, 2'b11, 1'b0, 1'b0, 1'b0, "R9");
    run_frame(9'h17F, 3'd2, 2'b10, 1'b1, 1'b0, 1'b0, "R9");
  endtask

  task automatic t_mangle;
    run_frame(9'h0B6, 3'd3, 2'b10, 1'b0, 1'b0, 1'b1, "R10");
    run_frame(9'h019, 3'd0, 2'b11, 1'b1, 1'b0, 1'b1, "R10");
  endtask

  task automatic t_odd_codes;
    run_frame(9'h1A5, 3'd6, 2'b10, 1'b0, 1'b0, 1'b0, "R3");
    run_frame(9'h15A, 3'd7, 2'b01, 1'b0, 1'b0, 1'b0, "R4");
  endtask

  task automatic t_reset_mid;
    logic v;
    in_data = 9'h000; cfg_len = 3'd3; cfg_parity = 2'b00; cfg_two_stop = 1'b0;
    in_valid = 1'b1;
    step(1'b1, v);
    in_valid = 1'b0;
    step(1'b0, v);
    step(1'b0, v);
    chk(line_out === 1'b0, "R11", "mid frame low", int'(line_out), 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(line_out === 1'b1, "R11", "line after reset", int'(line_out), 1);
    chk(busy === 1'b0, "R11", "busy after reset", int'(busy), 0);
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_no_tick();
    t_all_formats();
    t_chain();
    t_high_bits();
    t_mangle();
    t_odd_codes();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule